// File: doc/BRIEF.md
# Header User-Defined Field Extractor

This block watches a packet byte stream, one byte per beat, and pulls out up to nine 16-bit fields whose positions are set by software, one configuration byte per field slot. Each slot names an anchor (start of frame, end of the L2 header or end of the L3 header) and a distance from that anchor in 2-byte steps. The positions of the two header boundaries are not parsed here. They come in as sideband byte positions, presented together with the first byte of each frame.

The captured fields and one valid flag per slot feed a classifier key. A slot becomes valid only once the frame has delivered both bytes of its field. The results stay unchanged from the end of a frame until the next frame starts. A typical IPv4 layout selects end-of-L2 offsets 6 to 9 for the two addresses, split into 16-bit halves, and end-of-L3 offsets 0 and 1 for the two L4 ports.

Top module: `udfx_extractor`

## Requirements
- R1: After reset, every slot is invalid with data 0, `slot_count` is 0 and `frame_done` is 0.
- R2: A slot configuration byte uses bits [6:5] as the anchor: 0 is start of frame (byte position 0), 2 is `l2_end` and 3 is `l3_end`. Bits [4:0] give the offset in units of 2 bytes, and bit 7 is ignored. With target T = anchor position + 2*offset, the field is {byte at T, byte at T+1}, with the earlier byte in bits [15:8]. Slot i occupies `slot_cfg[8i+7:8i]`, `udf_data[16i+15:16i]` and `udf_valid[i]`.
- R3: A slot whose whole configuration byte is 0 is unused and never valid. `slot_count` equals the number of nonzero configuration bytes sampled at the last start of frame.
- R4: Anchor value 1 is reserved, and a slot that selects it stays invalid.
- R5: A slot becomes valid only if the frame contains byte position T+1. An invalid slot reads 0 on its data bits, even if its first byte was already captured.
- R6: A slot's valid flag and data appear on the clock edge that registers the beat carrying byte T+1, including when that beat also ends the frame.
- R7: Between the end of one frame and the next start of frame, the data, valid flags and `slot_count` hold their values. Beats with `in_valid` high that are outside a frame and carry no start of frame are ignored, and so are changes to the configuration and boundary inputs during that time.
- R8: The configuration and the two boundary positions are sampled on the start-of-frame beat. Changes to them later in the frame have no effect.
- R9: `frame_done` rises after the end-of-frame beat and falls after the next start-of-frame beat. A single-byte frame, which carries both marks, leaves it high.
- R10: A start-of-frame beat inside an unfinished frame begins a new frame. It clears every valid flag set by the old frame and restarts the byte position at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A byte is present this cycle |
| in_sof | input | 1 | This byte is the first byte of a frame |
| in_eof | input | 1 | This byte is the last byte of a frame |
| in_byte | input | 8 | Stream byte |
| l2_end | input | POS_W (8) | Byte position just after the L2 header, sampled at start of frame |
| l3_end | input | POS_W (8) | Byte position just after the L3 header, sampled at start of frame |
| slot_cfg | input | NUM_SLOTS*8 (72) | One configuration byte per slot |
| udf_data | output | NUM_SLOTS*16 (144) | Captured fields, slot 0 in the low bits |
| udf_valid | output | NUM_SLOTS (9) | Per-slot field valid flag |
| slot_count | output | $clog2(NUM_SLOTS+1) (4) | Number of configured slots |
| frame_done | output | 1 | The last frame has ended |

## Verification
The end-of-frame beat can be the same beat that carries a slot's second field byte. In that cycle the frame closes and the slot becomes valid together. Directed frames whose length is exactly T+2 provoke this, and frames one byte shorter act as the counterpart. The bench expects the slot to be valid in the first case and invalid with zero data in the second. A start of frame that arrives inside an unfinished frame also falls in the same cycle as the clearing of the old flags. The bench judges that case by whether only the second frame's fields show.

// File: rtl/udfx_pkg.sv
package udfx_pkg;
    localparam int CFG_W = 8;
    localparam int FIELD_W = 16;

    typedef enum logic [1:0] {
        ANC_SOF  = 2'd0,
        ANC_RSVD = 2'd1,
        ANC_L2   = 2'd2,
        ANC_L3   = 2'd3
    } anchor_e;
endpackage

// File: rtl/udfx_slot.sv
module udfx_slot
    import udfx_pkg::*;
#(
    parameter int POS_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 beat_i,
    input  logic                 sof_i,
    input  logic [POS_W+1:0]     pos_i,
    input  logic [7:0]           byte_i,
    input  logic                 in_use_i,
    input  logic [6:0]           cfg_i,
    input  logic [POS_W-1:0]     l2_i,
    input  logic [POS_W-1:0]     l3_i,
    output logic [FIELD_W-1:0]   field_o,
    output logic                 valid_o
);
    localparam int TW = POS_W + 2;

    typedef struct packed {
        logic [FIELD_W-1:0] field;
        logic               valid;
    } slot_st_t;

    slot_st_t      st_d, st_q;
    anchor_e       anchor;
    logic          usable;
    logic [TW-1:0] base;
    logic [TW-1:0] tgt_hi;
    logic [TW-1:0] tgt_lo;

    always_comb begin
        anchor = anchor_e'(cfg_i[6:5]);
        usable = in_use_i && (anchor != ANC_RSVD);
        case (anchor)
            ANC_L2:  base = {2'b00, l2_i};
            ANC_L3:  base = {2'b00, l3_i};
            default: base = '0;
        endcase
        tgt_hi = base + {{(TW-6){1'b0}}, cfg_i[4:0], 1'b0};
        tgt_lo = tgt_hi + TW'(1);

        st_d = st_q;
        if (beat_i && sof_i) begin
            st_d = '0;
        end
        if (beat_i && usable) begin
            if (pos_i == tgt_hi) begin
                st_d.field[15:8] = byte_i;
            end
            if (pos_i == tgt_lo) begin
                st_d.field[7:0] = byte_i;
                st_d.valid      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign field_o = st_q.field;
    assign valid_o = st_q.valid;

    // R6: a flag can only rise after a stream beat
    a_r6_rise_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.valid) |-> $past(beat_i));

    // R10: a flag can only drop after a start-of-frame beat
    a_r10_fall_on_sof: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.valid) |-> $past(beat_i && sof_i));
endmodule

// File: rtl/udfx_extractor.sv
module udfx_extractor
    import udfx_pkg::*;
#(
    parameter int NUM_SLOTS = 9,
    parameter int POS_W     = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic                           in_sof,
    input  logic                           in_eof,
    input  logic [7:0]                     in_byte,
    input  logic [POS_W-1:0]               l2_end,
    input  logic [POS_W-1:0]               l3_end,
    input  logic [NUM_SLOTS*CFG_W-1:0]     slot_cfg,
    output logic [NUM_SLOTS*FIELD_W-1:0]   udf_data,
    output logic [NUM_SLOTS-1:0]           udf_valid,
    output logic [$clog2(NUM_SLOTS+1)-1:0] slot_count,
    output logic                           frame_done
);
    localparam int TW    = POS_W + 2;
    localparam int CNT_W = $clog2(NUM_SLOTS + 1);
    localparam logic [TW-1:0] POS_MAX = '1;

    typedef struct packed {
        logic                       in_frame;
        logic [TW-1:0]              pos;
        logic [NUM_SLOTS*CFG_W-1:0] cfg;
        logic [POS_W-1:0]           l2;
        logic [POS_W-1:0]           l3;
        logic                       done;
    } ctl_st_t;

    ctl_st_t                    st_d, st_q;
    logic                       sof_beat;
    logic                       beat;
    logic [TW-1:0]              beat_pos;
    logic [NUM_SLOTS*CFG_W-1:0] eff_cfg;
    logic [POS_W-1:0]           eff_l2;
    logic [POS_W-1:0]           eff_l3;
    logic [CNT_W-1:0]           cnt;
    logic [NUM_SLOTS*FIELD_W-1:0] raw_field;

    always_comb begin
        sof_beat = in_valid && in_sof;
        beat     = in_valid && (in_sof || st_q.in_frame);
        beat_pos = sof_beat ? '0 : st_q.pos;
        eff_cfg  = sof_beat ? slot_cfg : st_q.cfg;
        eff_l2   = sof_beat ? l2_end : st_q.l2;
        eff_l3   = sof_beat ? l3_end : st_q.l3;

        st_d = st_q;
        if (sof_beat) begin
            st_d.cfg      = slot_cfg;
            st_d.l2       = l2_end;
            st_d.l3       = l3_end;
            st_d.in_frame = 1'b1;
            st_d.done     = 1'b0;
        end
        if (beat) begin
            st_d.pos = (beat_pos == POS_MAX) ? POS_MAX : beat_pos + TW'(1);
            if (in_eof) begin
                st_d.in_frame = 1'b0;
                st_d.done     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cnt = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            cnt = cnt + CNT_W'(|st_q.cfg[i*CFG_W +: CFG_W]);
        end
    end

    assign slot_count = cnt;
    assign frame_done = st_q.done;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        udfx_slot #(.POS_W(POS_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .beat_i   (beat),
            .sof_i    (sof_beat),
            .pos_i    (beat_pos),
            .byte_i   (in_byte),
            .in_use_i (|eff_cfg[g*CFG_W +: CFG_W]),
            .cfg_i    (eff_cfg[g*CFG_W +: 7]),
            .l2_i     (eff_l2),
            .l3_i     (eff_l3),
            .field_o  (raw_field[g*FIELD_W +: FIELD_W]),
            .valid_o  (udf_valid[g])
        );

        assign udf_data[g*FIELD_W +: FIELD_W] =
            udf_valid[g] ? raw_field[g*FIELD_W +: FIELD_W] : '0;

        // R3: a valid slot was configured with a nonzero byte
        a_r3_valid_needs_cfg: assert property (@(posedge clk) disable iff (!rst_n)
            udf_valid[g] |-> (|st_q.cfg[g*CFG_W +: CFG_W]));

        // R4: reserved anchor never yields a valid field
        a_r4_reserved_invalid: assert property (@(posedge clk) disable iff (!rst_n)
            udf_valid[g] |-> (st_q.cfg[g*CFG_W+5 +: 2] != 2'b01));
    end

    // R9: end-of-frame beat raises the done flag
    a_r9_done_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eof && (in_sof || st_q.in_frame)) |=> frame_done);

    // R9: a start of frame without end clears the done flag
    a_r9_sof_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && !in_eof) |=> !frame_done);

    // R7: with no beat, every result holds
    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(udf_valid) && $stable(udf_data) && $stable(slot_count)));
endmodule

// File: tb/sim_udfx_extractor.sv
module sim_udfx_extractor;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 9;
    localparam int PW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_sof = 1'b0;
    logic              in_eof = 1'b0;
    logic [7:0]        in_byte = '0;
    logic [PW-1:0]     l2_end = '0;
    logic [PW-1:0]     l3_end = '0;
    logic [NS*8-1:0]   slot_cfg = '0;
    logic [NS*16-1:0]  udf_data;
    logic [NS-1:0]     udf_valid;
    logic [3:0]        slot_count;
    logic              frame_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] fb [0:255];
    logic [7:0] ecfg [0:NS-1];
    int el2, el3, elen;

    always #(CLK_PERIOD/2) clk = ~clk;

    udfx_extractor #(.NUM_SLOTS(NS), .POS_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .in_byte(in_byte), .l2_end(l2_end), .l3_end(l3_end),
        .slot_cfg(slot_cfg), .udf_data(udf_data), .udf_valid(udf_valid),
        .slot_count(slot_count), .frame_done(frame_done)
    );

    task automatic chk(input string tag, input int act, input int expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic int exp_target(input int s);
        int a = (ecfg[s] >> 5) & 3;
        int base = (a == 2) ? el2 : (a == 3) ? el3 : 0;
        return base + 2 * (ecfg[s] & 31);
    endfunction

    function automatic bit exp_valid(input int s);
        int a = (ecfg[s] >> 5) & 3;
        if (ecfg[s] == 0 || a == 1) return 0;
        return (exp_target(s) + 1) < elen;
    endfunction

    function automatic int exp_data(input int s);
        int t = exp_target(s);
        if (!exp_valid(s)) return 0;
        return {fb[t], fb[t+1]};
    endfunction

    function automatic int exp_count();
        int c = 0;
        for (int s = 0; s < NS; s++) if (ecfg[s] != 0) c++;
        return c;
    endfunction

    task automatic check_all(input string tag);
        for (int s = 0; s < NS; s++) begin
            chk($sformatf("R5 valid slot %0d %s", s, tag), int'(udf_valid[s]), int'(exp_valid(s)));
            chk($sformatf("R2 data slot %0d %s", s, tag), int'(udf_data[s*16 +: 16]), exp_data(s));
        end
        chk($sformatf("R3 slot_count %s", tag), int'(slot_count), exp_count());
        chk($sformatf("R9 frame_done %s", tag), int'(frame_done), 1);
    endtask

    function automatic logic [7:0] rand_cfg();
        int k = $urandom % 8;
        if (k == 0) return 8'h00;
        if (k == 1) return {($urandom % 2 == 0) ? 1'b0 : 1'b1, 2'b01, 5'($urandom)};
        return {1'($urandom), (k < 4) ? 2'b00 : (k < 6) ? 2'b10 : 2'b11, 5'($urandom)};
    endfunction

    task automatic drive_cfg();
        for (int s = 0; s < NS; s++) slot_cfg[s*8 +: 8] = ecfg[s];
        l2_end = PW'(el2);
        l3_end = PW'(el3);
    endtask

    task automatic scramble();
        slot_cfg = {$urandom, $urandom, $urandom};
        l2_end = PW'($urandom);
        l3_end = PW'($urandom);
    endtask

    // sends fb[0..n-1]; with_eof=0 leaves the frame open
    task automatic send(input int n, input bit with_eof);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while ($urandom % 4 == 0) begin
                in_valid = 1'b0;
                in_sof = 1'($urandom);
                in_eof = 1'($urandom);
                in_byte = 8'($urandom);
                @(negedge clk);
            end
            if (i == 1) chk("R9 done low after sof", int'(frame_done), 0);
            in_valid = 1'b1;
            in_sof = (i == 0);
            in_eof = with_eof && (i == n - 1);
            in_byte = fb[i];
            if (i == 0) drive_cfg(); else scramble();
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof = 1'b0;
        in_eof = 1'b0;
    endtask

    task automatic stray_idle(input int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'($urandom);
            in_sof = 1'b0;
            in_eof = 1'($urandom);
            in_byte = 8'($urandom);
            scramble();
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_eof = 1'b0;
    endtask

    task automatic fill_bytes();
        for (int i = 0; i < 256; i++) fb[i] = 8'($urandom);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 valid after reset", int'(udf_valid), 0);
        chk("R1 data after reset", int'(udf_data != '0), 0);
        chk("R1 count after reset", int'(slot_count), 0);
        chk("R1 done after reset", int'(frame_done), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3: IPv4 style layout, full frame
        fill_bytes();
        ecfg = '{8'h46, 8'h47, 8'h48, 8'h49, 8'h60, 8'h61, 8'h00, 8'h00, 8'h00};
        el2 = 14; el3 = 34; elen = 60;
        send(elen, 1);
        check_all("ipv4 layout");
        stray_idle(12);
        check_all("R7 hold after stray beats");

        // R5: frame one byte short of slot 5 low byte
        fill_bytes();
        elen = 37;
        send(elen, 1);
        check_all("R5 short frame");
        chk("R5 slot5 invalid short", int'(udf_valid[5]), 0);

        // R6: end of frame on the low byte of slot 5
        fill_bytes();
        elen = 38;
        send(elen, 1);
        check_all("R6 eof on low byte");
        chk("R6 slot5 valid at eof", int'(udf_valid[5]), 1);

        // R4: reserved anchor, and bit 7 ignored
        fill_bytes();
        ecfg = '{8'h21, 8'h3F, 8'hA1, 8'h02, 8'h20, 8'hC0, 8'h00, 8'h41, 8'h7F};
        el2 = 20; el3 = 50; elen = 150;
        send(elen, 1);
        check_all("R4 reserved anchor");
        chk("R4 slot0 reserved", int'(udf_valid[0]), 0);
        chk("R4 slot4 reserved", int'(udf_valid[4]), 0);

        // R9: single byte frame keeps done high
        fill_bytes();
        elen = 1;
        send(elen, 1);
        check_all("R9 single byte frame");

        // R10: restart inside an open frame
        fill_bytes();
        for (int s = 0; s < NS; s++) ecfg[s] = 8'(s + 1);
        el2 = 14; el3 = 34; elen = 40;
        send(elen, 0);
        chk("R10 open frame done low", int'(frame_done), 0);
        fill_bytes();
        for (int s = 0; s < NS; s++) ecfg[s] = (s < 3) ? 8'(8 + s) : 8'h00;
        elen = 17;
        send(elen, 1);
        check_all("R10 restart");

        // R8 and random mix
        for (int f = 0; f < 200; f++) begin
            fill_bytes();
            for (int s = 0; s < NS; s++) ecfg[s] = rand_cfg();
            el2 = 10 + ($urandom % 21);
            el3 = el2 + 20 + ($urandom % 41);
            elen = 1 + ($urandom % 200);
            send(elen, 1);
            check_all($sformatf("R8 random frame %0d", f));
            if (f % 20 == 0) begin
                stray_idle(5);
                check_all("R7 random hold");
            end
        end

        finish_run();
    end
endmodule